// File: doc/BRIEF.md
# Two-Read One-Write Program Register File

This block holds the general-purpose registers of a small 64-bit processor. It keeps fifteen 64-bit entries, each selected by a 4-bit identifier. The two read ports are asynchronous: each output follows its address with no clock in the path. The single write port stores its data at the rising clock edge. One identifier value is reserved as a null selector, and it turns off whichever access it is given.

The decode stage of a pipeline uses the two read ports to fetch operands. The write-back stage uses the write port to commit results. The block has no internal forwarding. A read of a register that is being written in the same cycle returns the stored value until the edge. Forwarding is left to the pipeline around the block.

Top module: `prf_2r1w`

## Requirements
- R1: The storage holds 15 entries of 64 bits, addressed by the identifiers 0x0 through 0xE.
- R2: When the write enable input is high and the write identifier is 0x0 to 0xE, that entry takes the write data at the rising clock edge. No other entry changes at that edge.
- R3: A write addressed to identifier 0xF changes no entry.
- R4: Read port A drives the contents of the entry named by its identifier, with no clock in the path.
- R5: Read port B drives the contents of the entry named by its identifier, independently of port A.
- R6: A read at identifier 0xF returns all zeros on either port.
- R7: A read of the entry being written in the same cycle returns the old value until the clock edge and the new value after it.
- R8: While the synchronous active-high reset is asserted at a rising edge, every entry becomes zero, and a write in that cycle is ignored.
- R9: Identifier 0x4 (the stack pointer by convention) is stored and read back like any other entry.
- R10: Both reads and one write may all be used in the same cycle, including both reads at the same identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all entries |
| rd_a_id | input | 4 | Identifier for read port A (0xF = none) |
| rd_a_data | output | 64 | Contents read on port A |
| rd_b_id | input | 4 | Identifier for read port B (0xF = none) |
| rd_b_data | output | 64 | Contents read on port B |
| wr_en | input | 1 | Write enable |
| wr_id | input | 4 | Identifier for the write port (0xF = none) |
| wr_data | input | 64 | Data to store |

## Verification
The bench targets the null identifier in three roles: as a write target, where a decoder that wrapped or aliased it would corrupt an entry, and as a read address on each port, where it must return zeros rather than stale or undefined data. It also reads an entry in the same cycle it is written. A design with a hidden bypass would show the new value one cycle early, and a read path with a stray register would show it one cycle late. Further checks cover writes at both ends of the identifier range, a write under reset, and the stack pointer entry. These catch an off-by-one decoder, a write that leaks into a neighbouring entry, or a reset that lets a write through.

// File: rtl/prf_pkg.sv
package prf_pkg;
   localparam int unsigned PRF_DATA_W = 64;
   localparam int unsigned PRF_ID_W   = 4;
   localparam int unsigned PRF_NULL   = (1 << PRF_ID_W) - 1;
endpackage

// File: rtl/prf_wr_decode.sv
module prf_wr_decode #(
   parameter int unsigned ID_W    = 4,
   parameter int unsigned ENTRIES = 15
) (
   input  logic                wr_en,
   input  logic [ID_W-1:0]     wr_id,
   output logic [ENTRIES-1:0]  wr_sel
);
   localparam int unsigned SPACE = 1 << ID_W;

   initial begin
      if (ENTRIES >= SPACE) $error("ENTRIES must leave room for a null identifier");
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
      assign wr_sel[g] = wr_en && (wr_id == ID_W'(g));
   end

   always_comb begin
      AST_WR_ONEHOT: assert ($onehot0(wr_sel)); // R2
   end
endmodule

// File: rtl/prf_entry.sv
module prf_entry #(
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= din;
   end

   AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q)); // R3
   AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (rst)
      load |=> (q == $past(din))); // R2
endmodule

// File: rtl/prf_rd_mux.sv
module prf_rd_mux #(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned ID_W    = 4,
   parameter int unsigned ENTRIES = 15
) (
   input  logic [ENTRIES-1:0][DATA_W-1:0] store,
   input  logic [ID_W-1:0]                id,
   output logic [DATA_W-1:0]              dout
);
   always_comb begin
      dout = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (id == ID_W'(i)) dout = store[i];
      end
   end

   always_comb begin
      if (int'(id) >= ENTRIES) begin
         AST_RD_NULL_ZERO: assert (dout == '0); // R6
      end
   end
endmodule

// File: rtl/prf_2r1w.sv
module prf_2r1w
   import prf_pkg::*;
#(
   parameter int unsigned DATA_W  = PRF_DATA_W,
   parameter int unsigned ID_W    = PRF_ID_W,
   parameter int unsigned ENTRIES = (1 << ID_W) - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ID_W-1:0]   rd_a_id,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [ID_W-1:0]   rd_b_id,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int unsigned NULL_ID = (1 << ID_W) - 1;

   initial begin
      if (DATA_W < 1)                $error("DATA_W must be positive");
      if (ENTRIES > NULL_ID)         $error("null identifier would alias storage");
   end

   logic [ENTRIES-1:0]             wr_sel;
   logic [ENTRIES-1:0][DATA_W-1:0] store;

   prf_wr_decode #(.ID_W(ID_W), .ENTRIES(ENTRIES)) u_dec (
      .wr_en(wr_en), .wr_id(wr_id), .wr_sel(wr_sel));

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      prf_entry #(.DATA_W(DATA_W)) u_ent (
         .clk(clk), .rst(rst), .load(wr_sel[g]), .din(wr_data), .q(store[g]));
   end

   prf_rd_mux #(.DATA_W(DATA_W), .ID_W(ID_W), .ENTRIES(ENTRIES)) u_rda (
      .store(store), .id(rd_a_id), .dout(rd_a_data));
   prf_rd_mux #(.DATA_W(DATA_W), .ID_W(ID_W), .ENTRIES(ENTRIES)) u_rdb (
      .store(store), .id(rd_b_id), .dout(rd_b_data));

   AST_NULL_WRITE_NOP: assert property (@(posedge clk) disable iff (rst)
      (wr_id == ID_W'(NULL_ID)) |=> $stable(store)); // R3
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (store == '0)); // R8
   AST_SAME_ID_MATCH: assert property (@(posedge clk) disable iff (rst)
      (rd_a_id == rd_b_id) |-> (rd_a_data == rd_b_data)); // R10
endmodule

// File: tb/prf_2r1w_bench.sv
module prf_2r1w_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst;
   logic [3:0]  rd_a_id, rd_b_id, wr_id;
   logic [63:0] rd_a_data, rd_b_data, wr_data;
   logic        wr_en;

   int checks = 0;
   int fails  = 0;
   logic [63:0] model [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   prf_2r1w u_prf_2r1w (
      .clk(clk), .rst(rst),
      .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
      .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_id(wr_id), .wr_data(wr_data));

   // reference model updated at each edge
   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 16; i++) model[i] <= '0;
      end else if (wr_en && wr_id != 4'hF) begin
         model[wr_id] <= wr_data;
      end
   end

   function automatic logic [63:0] expect_rd(input logic [3:0] id);
      return (id == 4'hF) ? 64'h0 : model[id];
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // per-clock comparison against the model, sampled mid-cycle
   always @(negedge clk) begin
      if (!rst) begin
         chk("R4", rd_a_data, expect_rd(rd_a_id));
         chk("R5", rd_b_data, expect_rd(rd_b_id));
      end
   end

   task automatic wr(input logic [3:0] id, input logic [63:0] d);
      wr_en = 1; wr_id = id; wr_data = d;
      @(posedge clk); #1;
      wr_en = 0; wr_id = 4'hF;
   endtask

   task automatic sweep(input string req);
      for (int i = 0; i < 16; i++) begin
         rd_a_id = 4'(i); rd_b_id = 4'(15 - i); #1;
         chk(req, rd_a_data, expect_rd(4'(i)));
         chk(req, rd_b_data, expect_rd(4'(15 - i)));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst = 1; wr_en = 0; wr_id = 4'hF; wr_data = '0; rd_a_id = 0; rd_b_id = 0;
      for (int i = 0; i < 16; i++) model[i] = 'x;
      // write during reset must be ignored (R8)
      @(negedge clk); wr_en = 1; wr_id = 4'h3; wr_data = 64'hDEAD;
      @(posedge clk); #1; wr_en = 0; wr_id = 4'hF;
      @(negedge clk); rst = 0;
      sweep("R8");

      // fill every entry, ends of range included (R1, R2)
      for (int i = 0; i < 15; i++) wr(4'(i), {8{4'(i), 4'hA}} ^ 64'(i * 64'h1111_0000_0001));
      sweep("R1");
      sweep("R2");

      // null write (R3)
      wr(4'hF, 64'hFFFF_FFFF_FFFF_FFFF);
      sweep("R3");

      // null read zeros on both ports (R6)
      rd_a_id = 4'hF; rd_b_id = 4'hF; #1;
      chk("R6", rd_a_data, 64'h0);
      chk("R6", rd_b_data, 64'h0);

      // same-cycle read of written entry: old before edge, new after (R7)
      @(negedge clk);
      rd_a_id = 4'h7; rd_b_id = 4'h7;
      wr_en = 1; wr_id = 4'h7; wr_data = 64'h0123_4567_89AB_CDEF;
      #1;
      chk("R7", rd_a_data, model[7]);
      chk("R10", rd_b_data, model[7]);
      @(posedge clk); #1;
      wr_en = 0; wr_id = 4'hF;
      chk("R7", rd_a_data, 64'h0123_4567_89AB_CDEF);
      chk("R10", rd_b_data, 64'h0123_4567_89AB_CDEF);

      // stack pointer entry is ordinary (R9)
      wr(4'h4, 64'h0000_0000_0000_0100);
      rd_a_id = 4'h4; rd_b_id = 4'h3; #1;
      chk("R9", rd_a_data, 64'h100);
      chk("R9", rd_b_data, model[3]);
      wr(4'h4, 64'h0000_0000_0000_00F8);
      #1; chk("R9", rd_a_data, 64'hF8);

      // top and bottom identifiers (R2)
      wr(4'hE, 64'hAAAA_5555_AAAA_5555);
      wr(4'h0, 64'h5555_AAAA_5555_AAAA);
      sweep("R2");

      // reset after activity (R8)
      @(negedge clk); rst = 1;
      @(posedge clk); #1; rst = 0;
      sweep("R8");

      repeat (2) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule